// File: doc/BRIEF.md
# Power-Management Event Register Block

This block is the register file behind a chipset power-management I/O window. It keeps a 16-bit event status register and a 16-bit event enable register for four wake and attention sources: timer overflow, global lock release, power button and real-time-clock alarm. It also keeps a 16-bit control register, a free-running power-management timer, a bank of general-purpose event status and enable bytes, and a pair of 32-bit system-management words. From the masked event status it drives a level-sensitive interrupt line, `sci`, toward the interrupt controller.

Software reaches the registers through a dword-addressed bus. Each access carries a byte address whose two low bits are zero, read and write strobes and four byte enables. A read returns data in the same cycle. The window appears on the bus only after a nonzero, window-aligned base has been loaded through a separate base port. Hardware events arrive as single-cycle pulses. The timer advances once for each cycle in which `tick` is high.

Top module: `pmev_ctrl`

## Requirements
- R1: After reset the window base is zero, so no read decodes and every read returns 0. `sci` is low. Once a base is loaded, every register (event status, event enable, control, timer count, event bank, system-management words) reads 0.
- R2: An access decodes only when all three hold: the base is nonzero, bus address bits [15:6] equal base bits [15:6], and bus address bits [1:0] are zero. Any other read returns 0 and any other write is ignored. A base write whose bits [5:0] are not zero is rejected, and the old base is kept.
- R3: Dword offset 0x00 holds event status in bits [15:0] and event enable in bits [31:16]. Only positions 0 (timer), 5 (global lock), 8 (power button) and 10 (RTC) exist in either half; all other bits read 0. Writing a 1 to a status bit in an enabled byte lane clears it. A hardware set in the same cycle as a clear wins. Enable bits are plain read/write per byte lane.
- R4: `sci` is the OR, over the four positions, of status AND enable. It is registered, so it changes one clock after the status or enable update that causes it.
- R5: A cycle with `pwrbtn_req` high sets status bit 8.
- R6: The timer count reads at offset 0x08, zero-extended. It increments on each cycle with `tick` high. Status bit 0 is set on a tick that toggles the counter's top bit, but only while enable bit 0 is 1 and status bit 0 is 0. A toggle while enable bit 0 is 0 sets nothing.
- R7: The control register at offset 0x04 is read/write in bits [15:0] per byte lane. Bits [31:16] read 0.
- R8: Event-bank status bytes sit at offset 0x20 and enable bytes at offset 0x24, one byte per lane, each lane independent. A high bit of `gpe_evt` sets its status bit. A written 1 clears a status bit. Enable bytes are read/write.
- R9: The system-management enable word at offset 0x30 is written only by a write with all four byte enables high. Any partial write leaves it unchanged.
- R10: The system-management status word at offset 0x34 gathers the bits of `smi_evt` by OR and is read-only to the bus. Offset 0x38 reads 0. Within 0x30 to 0x3C, a read without all four byte enables high returns 0.
- R11: A cycle with `rtc_alarm` high sets status bit 10. A cycle with `gl_release` high sets status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer advance enable |
| base_wr | input | 1 | Load strobe for the window base |
| base_val | input | 16 | Window base value |
| bus_addr | input | 16 | Byte address of an aligned dword |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| pwrbtn_req | input | 1 | Power-down request pulse |
| rtc_alarm | input | 1 | RTC alarm event pulse |
| gl_release | input | 1 | Global lock release event pulse |
| gpe_evt | input | 32 | Event-bank set pulses |
| smi_evt | input | 32 | System-management status set pulses |
| sci | output | 1 | Level interrupt output |

## Verification
The interrupt line is tried in two ways. First, with all four status bits set, every one of the sixteen enable patterns is applied. Second, a single status source is set and the enable is steered onto it and off it. Together these separate a correct OR of masked sources from an unmasked or wrongly positioned one. Write-one-to-clear is driven with partial byte lanes and with an event arriving in the same cycle as the clear, which shows whether lane masking and set priority are right. The timer crosses its top-bit toggle three times: with the enable off, with it on, and again with the status already set. Every pattern of byte enables is swept over the event-bank enable bytes and over partial accesses to the system-management words, which shows whether lanes are handled one by one or as a whole word.

// File: rtl/pmev_pkg.sv
package pmev_pkg;

    // Event bit positions shared by status and enable halves
    localparam int EVB_TMR = 0;
    localparam int EVB_GL  = 5;
    localparam int EVB_PB  = 8;
    localparam int EVB_RTC = 10;

    localparam logic [15:0] EV_MASK = 16'h0521;

    // Dword index inside the window
    localparam int WD_EVT     = 0;
    localparam int WD_CTRL    = 1;
    localparam int WD_TMR     = 2;
    localparam int WD_GPE_STS = 8;
    localparam int WD_GPE_EN  = 9;
    localparam int WD_SMI_EN  = 12;
    localparam int WD_SMI_STS = 13;
    localparam int WD_SMI_LO  = 12;
    localparam int WD_SMI_HI  = 15;

    typedef struct packed {
        logic tmr;
        logic gl;
        logic pb;
        logic rtc;
    } ev_pulse_t;

    typedef struct packed {
        logic evt;
        logic ctrl;
        logic gpe_sts;
        logic gpe_en;
        logic smi_en;
    } wr_sel_t;

    function automatic logic [31:0] lane_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

    function automatic logic [15:0] ev_vector(input ev_pulse_t p);
        logic [15:0] v;
        v = '0;
        v[EVB_TMR] = p.tmr;
        v[EVB_GL]  = p.gl;
        v[EVB_PB]  = p.pb;
        v[EVB_RTC] = p.rtc;
        return v;
    endfunction

endpackage

// File: rtl/pmev_timer.sv
module pmev_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             armed,
    output logic [TMR_W-1:0] count,
    output logic             ovf
);
    // R6: top bit toggles on the tick that carries out of the lower bits
    logic carry_low;
    assign carry_low = &count[TMR_W-2:0];
    assign ovf       = tick & armed & carry_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/pmev_evregs.sv
module pmev_evregs
    import pmev_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_evt,
    input  logic        wr_ctrl,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  ev_pulse_t   pulses,
    output logic [15:0] sts,
    output logic [15:0] en,
    output logic [15:0] ctrl,
    output logic [15:0] clr,
    output logic        tmr_armed,
    output logic        sci
);
    logic [31:0] m;
    logic [15:0] setv;
    logic [15:0] sts_n;
    logic [15:0] en_n;
    logic [15:0] ctrl_n;

    assign m    = lane_mask(be);
    assign setv = ev_vector(pulses);
    // R3: write-one-to-clear on enabled lanes, a set in the same cycle wins
    assign clr  = wr_evt ? (wdata[15:0] & m[15:0]) : 16'h0000;

    always_comb begin
        sts_n = ((sts & ~clr) | setv) & EV_MASK;
        en_n  = en;
        if (wr_evt) begin
            en_n = ((en & ~m[31:16]) | (wdata[31:16] & m[31:16])) & EV_MASK;
        end
        ctrl_n = ctrl;
        if (wr_ctrl) begin
            ctrl_n = (ctrl & ~m[15:0]) | (wdata[15:0] & m[15:0]);
        end
    end

    // R6: timer overflow can only be raised while enabled and not yet pending
    assign tmr_armed = en[EVB_TMR] & ~sts[EVB_TMR];

    always_ff @(posedge clk) begin
        if (rst) begin
            sts  <= '0;
            en   <= '0;
            ctrl <= '0;
            sci  <= 1'b0;
        end else begin
            sts  <= sts_n;
            en   <= en_n;
            ctrl <= ctrl_n;
            // R4: registered level from current masked status
            sci  <= |(sts & en & EV_MASK);
        end
    end
endmodule

// File: rtl/pmev_gpe.sv
module pmev_gpe #(
    parameter int GPE_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_sts,
    input  logic                   wr_en,
    input  logic [3:0]             be,
    input  logic [31:0]            wdata,
    input  logic [8*GPE_BYTES-1:0] evt,
    output logic [8*GPE_BYTES-1:0] sts,
    output logic [8*GPE_BYTES-1:0] en
);
    // R8: every byte lane is its own register
    for (genvar i = 0; i < GPE_BYTES; i++) begin : g_lane
        logic [7:0] wb;
        logic       hit;
        assign wb  = wdata[8*i +: 8];
        assign hit = be[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                sts[8*i +: 8] <= '0;
                en[8*i +: 8]  <= '0;
            end else begin
                sts[8*i +: 8] <= (sts[8*i +: 8] & ~((wr_sts && hit) ? wb : 8'h00))
                                 | evt[8*i +: 8];
                if (wr_en && hit) begin
                    en[8*i +: 8] <= wb;
                end
            end
        end
    end
endmodule

// File: rtl/pmev_smi.sv
module pmev_smi (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic [31:0] evt,
    output logic [31:0] en,
    output logic [31:0] sts
);
    logic full;
    assign full = &be;

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= '0;
            sts <= '0;
        end else begin
            // R9: only a full dword write lands
            if (wr_en && full) begin
                en <= wdata;
            end
            // R10: bus has no write path into the status word
            sts <= sts | evt;
        end
    end
endmodule

// File: rtl/pmev_ctrl.sv
module pmev_ctrl
    import pmev_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WIN_LOG2  = 6,
    parameter int TMR_W     = 24,
    parameter int GPE_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic                   base_wr,
    input  logic [ADDR_W-1:0]      base_val,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic [3:0]             bus_be,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic                   pwrbtn_req,
    input  logic                   rtc_alarm,
    input  logic                   gl_release,
    input  logic [8*GPE_BYTES-1:0] gpe_evt,
    input  logic [31:0]            smi_evt,
    output logic                   sci
);
    localparam int WORD_W   = WIN_LOG2 - 2;
    localparam int GPE_BITS = 8 * GPE_BYTES;

    logic [ADDR_W-1:0] io_base;
    logic              base_ok;
    logic              hit;
    logic [WORD_W-1:0] widx;
    wr_sel_t           wsel;

    logic [15:0]         ev_sts, ev_en, ev_ctrl, ev_clr;
    logic                tmr_armed, tmr_ovf;
    logic [TMR_W-1:0]    tmr_count;
    logic [GPE_BITS-1:0] gpe_sts, gpe_en;
    logic [31:0]         smi_en, smi_sts;
    ev_pulse_t           pulses;

    // R2: base must be window aligned
    assign base_ok = (base_val[WIN_LOG2-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            io_base <= '0;
        end else if (base_wr && base_ok) begin
            io_base <= base_val;
        end
    end

    // R2: window decode
    assign hit  = (io_base != '0)
                  && (bus_addr[ADDR_W-1:WIN_LOG2] == io_base[ADDR_W-1:WIN_LOG2])
                  && (bus_addr[1:0] == 2'b00);
    assign widx = bus_addr[WIN_LOG2-1:2];

    always_comb begin
        wsel         = '0;
        wsel.evt     = bus_wr && hit && (widx == WORD_W'(WD_EVT));
        wsel.ctrl    = bus_wr && hit && (widx == WORD_W'(WD_CTRL));
        wsel.gpe_sts = bus_wr && hit && (widx == WORD_W'(WD_GPE_STS));
        wsel.gpe_en  = bus_wr && hit && (widx == WORD_W'(WD_GPE_EN));
        wsel.smi_en  = bus_wr && hit && (widx == WORD_W'(WD_SMI_EN));
    end

    assign pulses.tmr = tmr_ovf;
    assign pulses.gl  = gl_release;
    assign pulses.pb  = pwrbtn_req;
    assign pulses.rtc = rtc_alarm;

    pmev_evregs u_ev (
        .clk       (clk),
        .rst       (rst),
        .wr_evt    (wsel.evt),
        .wr_ctrl   (wsel.ctrl),
        .be        (bus_be),
        .wdata     (bus_wdata),
        .pulses    (pulses),
        .sts       (ev_sts),
        .en        (ev_en),
        .ctrl      (ev_ctrl),
        .clr       (ev_clr),
        .tmr_armed (tmr_armed),
        .sci       (sci)
    );

    pmev_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .armed (tmr_armed),
        .count (tmr_count),
        .ovf   (tmr_ovf)
    );

    pmev_gpe #(.GPE_BYTES(GPE_BYTES)) u_gpe (
        .clk    (clk),
        .rst    (rst),
        .wr_sts (wsel.gpe_sts),
        .wr_en  (wsel.gpe_en),
        .be     (bus_be),
        .wdata  (bus_wdata),
        .evt    (gpe_evt),
        .sts    (gpe_sts),
        .en     (gpe_en)
    );

    pmev_smi u_smi (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wsel.smi_en),
        .be    (bus_be),
        .wdata (bus_wdata),
        .evt   (smi_evt),
        .en    (smi_en),
        .sts   (smi_sts)
    );

    // Read mux, same-cycle data
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && hit) begin
            if (widx >= WORD_W'(WD_SMI_LO) && widx <= WORD_W'(WD_SMI_HI)) begin
                // R10: only full dword reads see the SMI words
                if (&bus_be) begin
                    if (widx == WORD_W'(WD_SMI_EN))       bus_rdata = smi_en;
                    else if (widx == WORD_W'(WD_SMI_STS)) bus_rdata = smi_sts;
                end
            end else begin
                case (widx)
                    WORD_W'(WD_EVT):     bus_rdata = {ev_en, ev_sts};
                    WORD_W'(WD_CTRL):    bus_rdata = {16'h0000, ev_ctrl};
                    WORD_W'(WD_TMR):     bus_rdata = 32'(tmr_count);
                    WORD_W'(WD_GPE_STS): bus_rdata = 32'(gpe_sts);
                    WORD_W'(WD_GPE_EN):  bus_rdata = 32'(gpe_en);
                    default:             bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pmev_checker.sv
module pmev_checker #(
    parameter int ADDR_W   = 16,
    parameter int WIN_LOG2 = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              pwrbtn_req,
    input logic              rtc_alarm,
    input logic              sci,
    input logic [15:0]       ev_sts,
    input logic [15:0]       ev_en,
    input logic [15:0]       ev_clr,
    input logic [ADDR_W-1:0] io_base
);
    localparam logic [15:0] EVM = 16'h0521;

    assert_sci_level_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sci == $past(|(ev_sts & ev_en & EVM))));

    assert_pwrbtn_sets_R5: assert property (@(posedge clk) disable iff (rst)
        pwrbtn_req |=> ev_sts[8]);

    assert_rtc_sets_R11: assert property (@(posedge clk) disable iff (rst)
        rtc_alarm |=> ev_sts[10]);

    assert_base_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        io_base[WIN_LOG2-1:0] == '0);

    assert_no_decode_R2: assert property (@(posedge clk) disable iff (rst)
        (io_base == '0 && bus_rd) |-> (bus_rdata == 32'h0));

    assert_tmr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ev_sts[0] && !ev_clr[0]) |=> ev_sts[0]);

    assert_unused_zero_R3: assert property (@(posedge clk) disable iff (rst)
        ((ev_sts | ev_en) & ~EVM) == 16'h0000);
endmodule

bind pmev_ctrl pmev_checker #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .pwrbtn_req (pwrbtn_req),
    .rtc_alarm  (rtc_alarm),
    .sci        (sci),
    .ev_sts     (ev_sts),
    .ev_en      (ev_en),
    .ev_clr     (ev_clr),
    .io_base    (io_base)
);

// File: tb/sim_pmev_ctrl.sv
module sim_pmev_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        base_wr = 1'b0;
    logic [15:0] base_val = '0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwrbtn_req = 1'b0;
    logic        rtc_alarm = 1'b0;
    logic        gl_release = 1'b0;
    logic [31:0] gpe_evt = '0;
    logic [31:0] smi_evt = '0;
    logic        sci;

    int errors = 0;
    int checks = 0;
    logic [31:0] rv;

    localparam logic [15:0] BASE = 16'h0400;

    always #4 clk = ~clk;

    pmev_ctrl #(.TMR_W(8)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .base_wr(base_wr), .base_val(base_val),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwrbtn_req(pwrbtn_req),
        .rtc_alarm(rtc_alarm), .gl_release(gl_release), .gpe_evt(gpe_evt),
        .smi_evt(smi_evt), .sci(sci)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_be = be; bus_rd = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic set_base(input logic [15:0] v);
        @(negedge clk);
        base_val = v; base_wr = 1'b1;
        @(negedge clk);
        base_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    function automatic logic [15:0] spread(input logic [3:0] k);
        logic [15:0] v;
        v = '0;
        v[0] = k[0]; v[5] = k[1]; v[8] = k[2]; v[10] = k[3];
        return v;
    endfunction

    function automatic logic [31:0] bmask(input logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got %08h expected %08h", 32'h1, 32'h0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: base cleared, nothing decodes, sci low
        rd(BASE + 16'h00, 4'hF, rv); check("R1 no decode at reset", rv, 32'h0);
        check("R1 sci low", {31'b0, sci}, 32'h0);

        // R2: misaligned base rejected, undecoded write ignored
        set_base(BASE | 16'h0010);
        wr(BASE + 16'h04, 4'hF, 32'hFFFF_FFFF);
        set_base(BASE);
        rd(BASE + 16'h04, 4'hF, rv); check("R2 misaligned base / undecoded write", rv, 32'h0);

        // R1: defaults once decoding
        rd(BASE + 16'h00, 4'hF, rv); check("R1 event word default", rv, 32'h0);
        rd(BASE + 16'h08, 4'hF, rv); check("R1 timer default", rv, 32'h0);
        rd(BASE + 16'h20, 4'hF, rv); check("R1 bank status default", rv, 32'h0);
        rd(BASE + 16'h24, 4'hF, rv); check("R1 bank enable default", rv, 32'h0);
        rd(BASE + 16'h30, 4'hF, rv); check("R1 smi enable default", rv, 32'h0);
        rd(BASE + 16'h34, 4'hF, rv); check("R1 smi status default", rv, 32'h0);

        // R7: control register
        wr(BASE + 16'h04, 4'hF, 32'hFFFF_FFFF);
        rd(BASE + 16'h04, 4'hF, rv); check("R7 control full write", rv, 32'h0000_FFFF);
        wr(BASE + 16'h04, 4'h1, 32'h0000_0000);
        rd(BASE + 16'h04, 4'hF, rv); check("R7 control lane 0 write", rv, 32'h0000_FF00);

        // R2: outside window and unaligned addresses
        wr(BASE + 16'h44, 4'hF, 32'h0);
        wr(BASE + 16'h05, 4'hF, 32'h0);
        rd(BASE + 16'h04, 4'hF, rv); check("R2 outside/unaligned write ignored", rv, 32'h0000_FF00);
        rd(BASE + 16'h44, 4'hF, rv); check("R2 outside read zero", rv, 32'h0);
        rd(BASE + 16'h06, 4'hF, rv); check("R2 unaligned read zero", rv, 32'h0);

        // R5, R11: event sources
        @(negedge clk); pwrbtn_req = 1'b1; @(negedge clk); pwrbtn_req = 1'b0;
        rd(BASE, 4'hF, rv); check("R5 power button status", rv, 32'h0000_0100);
        check("R4 sci low with enables off", {31'b0, sci}, 32'h0);
        @(negedge clk); rtc_alarm = 1'b1; @(negedge clk); rtc_alarm = 1'b0;
        @(negedge clk); gl_release = 1'b1; @(negedge clk); gl_release = 1'b0;
        rd(BASE, 4'hF, rv); check("R11 rtc and lock status", rv, 32'h0000_0520);

        // R6: timer overflow with enable set
        wr(BASE, 4'hC, 32'h0001_0000);
        @(negedge clk);
        check("R4 sci low before timer status", {31'b0, sci}, 32'h0);
        ticks(128);
        check("R4 sci one cycle late", {31'b0, sci}, 32'h0);
        @(negedge clk);
        check("R4 sci raised by timer", {31'b0, sci}, 32'h1);
        rd(BASE + 16'h08, 4'hF, rv); check("R6 timer count", rv, 32'd128);
        rd(BASE, 4'hF, rv); check("R6 timer status set", rv, 32'h0001_0521);

        // R4: sweep of enable patterns with all status set
        for (int k = 0; k < 16; k++) begin
            wr(BASE, 4'hC, {spread(k[3:0]), 16'h0000});
            @(negedge clk);
            check($sformatf("R4 enable sweep %0d", k), {31'b0, sci}, {31'b0, (k != 0)});
        end

        // R3: unused enable bits read zero
        wr(BASE, 4'hC, 32'hFFFF_0000);
        rd(BASE, 4'hF, rv); check("R3 unused bits zero", rv, 32'h0521_0521);

        // R3: lane-masked clear
        wr(BASE, 4'h1, 32'h0000_FFFF);
        rd(BASE, 4'hF, rv); check("R3 clear lane 0 only", rv, 32'h0521_0500);

        // R3: set wins over same-cycle clear
        @(negedge clk);
        bus_addr = BASE; bus_be = 4'h3; bus_wdata = 32'h0000_0100; bus_wr = 1'b1; pwrbtn_req = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; pwrbtn_req = 1'b0;
        rd(BASE, 4'hF, rv); check("R3 set wins over clear", rv, 32'h0521_0500);
        wr(BASE, 4'h3, 32'h0000_0100);
        rd(BASE, 4'hF, rv); check("R3 clear bit 8", rv, 32'h0521_0400);

        // R4: single source steering
        wr(BASE, 4'hF, 32'h0100_FFFF);
        @(negedge clk);
        check("R4 cleared sources sci low", {31'b0, sci}, 32'h0);
        @(negedge clk); pwrbtn_req = 1'b1; @(negedge clk); pwrbtn_req = 1'b0;
        @(negedge clk);
        check("R4 power button raises sci", {31'b0, sci}, 32'h1);
        wr(BASE, 4'hC, 32'h0421_0000);
        @(negedge clk);
        check("R4 other enables do not pass", {31'b0, sci}, 32'h0);
        wr(BASE, 4'hF, 32'h0000_FFFF);

        // R6: toggle with enable off sets nothing (count 128 -> 0)
        ticks(128);
        rd(BASE, 4'hF, rv); check("R6 no status while disabled", rv, 32'h0);
        rd(BASE + 16'h08, 4'hF, rv); check("R6 timer wraps", rv, 32'h0);
        wr(BASE, 4'hC, 32'h0001_0000);
        ticks(128);
        rd(BASE, 4'hF, rv); check("R6 status on next toggle", rv, 32'h0001_0001);
        ticks(128);
        rd(BASE, 4'hF, rv); check("R6 status stays pending", rv, 32'h0001_0001);
        wr(BASE, 4'h1, 32'h0000_0001);
        rd(BASE, 4'hF, rv); check("R6 status cleared", rv, 32'h0001_0000);

        // R8: event bank
        @(negedge clk); gpe_evt = 32'hFFFF_FFFF; @(negedge clk); gpe_evt = 32'h0;
        rd(BASE + 16'h20, 4'hF, rv); check("R8 bank status set", rv, 32'hFFFF_FFFF);
        wr(BASE + 16'h20, 4'h5, 32'hFFFF_FFFF);
        rd(BASE + 16'h20, 4'hF, rv); check("R8 bank lane clear", rv, 32'hFF00_FF00);
        for (int b = 0; b < 16; b++) begin
            wr(BASE + 16'h24, 4'hF, 32'h0);
            wr(BASE + 16'h24, b[3:0], 32'hFFFF_FFFF);
            rd(BASE + 16'h24, 4'hF, rv);
            check($sformatf("R8 bank enable lanes %0d", b), rv, bmask(b[3:0]));
        end

        // R9, R10: system-management words
        wr(BASE + 16'h30, 4'hF, 32'h1234_5678);
        rd(BASE + 16'h30, 4'hF, rv); check("R9 smi enable full write", rv, 32'h1234_5678);
        for (int b = 0; b < 15; b++) begin
            wr(BASE + 16'h30, b[3:0], 32'hFFFF_FFFF);
            rd(BASE + 16'h30, 4'hF, rv);
            check($sformatf("R9 partial write %0d ignored", b), rv, 32'h1234_5678);
            rd(BASE + 16'h30, b[3:0], rv);
            check($sformatf("R10 partial read %0d zero", b), rv, 32'h0);
        end
        @(negedge clk); smi_evt = 32'h0000_00A0; @(negedge clk); smi_evt = 32'h0;
        wr(BASE + 16'h34, 4'hF, 32'hFFFF_FFFF);
        rd(BASE + 16'h34, 4'hF, rv); check("R10 smi status read-only", rv, 32'h0000_00A0);
        rd(BASE + 16'h38, 4'hF, rv); check("R10 unused smi offset zero", rv, 32'h0);

        // R1: reset again clears base and registers
        wr(BASE, 4'hF, 32'h0100_0000);
        @(negedge clk); pwrbtn_req = 1'b1; @(negedge clk); pwrbtn_req = 1'b0;
        @(negedge clk);
        check("R4 sci high before reset", {31'b0, sci}, 32'h1);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        check("R1 sci low after reset", {31'b0, sci}, 32'h0);
        rd(BASE + 16'h04, 4'hF, rv); check("R1 base cleared", rv, 32'h0);
        set_base(BASE);
        rd(BASE, 4'hF, rv); check("R1 event word cleared", rv, 32'h0);
        rd(BASE + 16'h04, 4'hF, rv); check("R1 control cleared", rv, 32'h0);

        summary();
    end
endmodule